// File: doc/BRIEF.md
# Table Pointer and Latch Unit

This block sits between a processor core and a word-wide program memory and carries table reads and table writes. It keeps a pointer register that addresses the program memory and a latch register that holds one memory word. Both registers are two bytes wide. The core moves data through an 8-bit bus, so each command carries a byte-select bit that picks the latch half (or pointer half) it touches.

The cycle sequencer issues commands on a valid/ready channel. A table read or table write takes two cycles. In the first cycle the command is accepted and the core-side byte moves. In the second cycle the core sees no work, the full word moves across the memory port, and the pointer may step forward. During that second cycle `cmd_ready` is low. A command held on the channel then waits and is taken on the next cycle. Every other command completes in the cycle it is accepted, and `cmd_ready` stays high. The memory port has no back-pressure. The memory must return `mem_rdata` for `mem_addr` within the same cycle that `mem_rd` is high, and it must accept a write in the cycle that `mem_wr` is high. Read results come back on `rd_data`, qualified by a one-cycle `rd_valid` pulse. The core always accepts this result.

Top module: `tpl_unit`

## Requirements
- R1: After reset, the pointer and the latch both read back as 0000h. `cmd_ready` is 1, and `mem_rd`, `mem_wr` and `rd_valid` are 0.
- R2: Command code 3 (latch byte write) copies `cmd_data` into the latch byte selected by `cmd_hi`: 0 selects bits [7:0] and 1 selects bits [15:8]. The other latch byte is unchanged.
- R3: Command codes 2 (latch byte read) and 5 (pointer byte read) raise `rd_valid` for exactly the cycle after acceptance. In that cycle `rd_data` holds the byte selected by `cmd_hi`, using the same bit positions as R2.
- R4: Command code 4 (pointer byte write) copies `cmd_data` into the pointer byte selected by `cmd_hi`. The other pointer byte is unchanged.
- R5: Command code 0 (table read) returns the latch byte selected by `cmd_hi`, as it was before the command, on `rd_data` in the cycle after acceptance. In that same cycle `mem_rd` is 1 and `mem_addr` equals the pointer. At the end of that cycle the whole latch takes `mem_rdata`.
- R6: Command code 1 (table write) writes `cmd_data` into the selected latch byte on acceptance. In the next cycle `mem_wr` is 1, `mem_addr` equals the pointer, and `mem_wdata` equals the updated latch.
- R7: `cmd_ready` is 0 during the second cycle of a table command and 1 at all other times. A command held valid during that second cycle is not taken until `cmd_ready` returns to 1.
- R8: With `cmd_inc` = 1 on a table command, the pointer becomes the accessed address plus one after the second cycle, wrapping from FFFFh to 0000h. With `cmd_inc` = 0 the pointer is unchanged. `cmd_inc` has no effect on non-table commands.
- R9: Command codes 6 and 7 change neither register. They raise no memory strobe, produce no `rd_valid`, and leave `cmd_ready` at 1.
- R10: `mem_rd` and `mem_wr` are never high together. Each is high only in the second cycle of a table command, and never for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code (0 table read, 1 table write, 2 latch read, 3 latch write, 4 pointer write, 5 pointer read) |
| cmd_hi | input | 1 | Byte select: 0 low byte, 1 high byte |
| cmd_inc | input | 1 | Step the pointer after a table command |
| cmd_data | input | BYTE_W | Byte from the core |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| rd_data | output | BYTE_W | Byte returned to the core |
| mem_rd | output | 1 | Program memory read strobe |
| mem_wr | output | 1 | Program memory write strobe |
| mem_addr | output | 2*BYTE_W | Program memory word address |
| mem_wdata | output | 2*BYTE_W | Word to write |
| mem_rdata | input | 2*BYTE_W | Word read, valid in the same cycle as `mem_rd` |

## Verification
Two functions meet in the second cycle of a table command. The memory access uses the pointer, and the post-increment rewrites that same pointer on the same edge. The access must see the old value, and the next command must see the new one. The bench provokes this by sweeping both table commands over every combination of byte select and increment. It uses pointer values that include FFFEh and FFFFh, which are the boundaries where the increment wraps. It judges each case by `mem_addr` at the strobe and by reading the pointer back afterwards. A second overlap, a command held on the channel during the no-op cycle, is judged by checking that `cmd_ready` is low there and that the held write lands only afterwards.

// File: rtl/tpl_pkg.sv
`timescale 1ns/1ps
package tpl_pkg;

  typedef enum logic [2:0] {
    OP_TBL_RD = 3'd0,
    OP_TBL_WR = 3'd1,
    OP_LAT_RD = 3'd2,
    OP_LAT_WR = 3'd3,
    OP_PTR_WR = 3'd4,
    OP_PTR_RD = 3'd5
  } tpl_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_NOP  = 1'b1
  } tpl_state_e;

  // One-hot decoded form of an accepted command
  typedef struct packed {
    logic tbl_rd;
    logic tbl_wr;
    logic lat_rd;
    logic lat_wr;
    logic ptr_wr;
    logic ptr_rd;
  } tpl_dec_t;

endpackage

// File: rtl/tpl_decode.sv
`timescale 1ns/1ps
module tpl_decode
  import tpl_pkg::*;
(
  input  logic       acc,
  input  logic [2:0] op,
  output tpl_dec_t   dec
);

  always_comb begin
    dec = '0;
    if (acc) begin
      case (op)
        OP_TBL_RD: dec.tbl_rd = 1'b1;
        OP_TBL_WR: dec.tbl_wr = 1'b1;
        OP_LAT_RD: dec.lat_rd = 1'b1;
        OP_LAT_WR: dec.lat_wr = 1'b1;
        OP_PTR_WR: dec.ptr_wr = 1'b1;
        OP_PTR_RD: dec.ptr_rd = 1'b1;
        default:   dec = '0;
      endcase
    end
  end

endmodule

// File: rtl/tpl_seq.sv
`timescale 1ns/1ps
module tpl_seq
  import tpl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_tbl,
  input  logic start_wr,
  input  logic start_inc,
  output logic ready,
  output logic ph2_rd,
  output logic ph2_wr,
  output logic ph2_inc
);

  tpl_state_e state_q;
  logic       wr_q;
  logic       inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      inc_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_tbl) begin
            state_q <= ST_NOP;
            wr_q    <= start_wr;
            inc_q   <= start_inc;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          inc_q   <= 1'b0;
        end
      endcase
    end
  end

  assign ready   = (state_q == ST_IDLE);
  assign ph2_rd  = (state_q == ST_NOP) && !wr_q;
  assign ph2_wr  = (state_q == ST_NOP) &&  wr_q;
  assign ph2_inc = (state_q == ST_NOP) &&  inc_q;

endmodule

// File: rtl/tpl_ptr.sv
`timescale 1ns/1ps
module tpl_ptr #(
  parameter  int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int NB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              ld_hi,
  input  logic [BYTE_W-1:0] ld_data,
  input  logic              inc_en,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [WORD_W-1:0] ptr
);

  logic [WORD_W-1:0] ptr_q;
  logic [WORD_W-1:0] nxt_load;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic lane_sel;
    assign lane_sel = (g == 1) ? ld_hi : !ld_hi;
    assign nxt_load[g*BYTE_W +: BYTE_W] =
      (ld_en && lane_sel) ? ld_data : ptr_q[g*BYTE_W +: BYTE_W];
  end

  // The increment and a byte load never coincide: loads are taken only when idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (inc_en) ptr_q <= ptr_q + WORD_W'(1);
    else             ptr_q <= nxt_load;
  end

  assign rd_byte = rd_hi ? ptr_q[WORD_W-1:BYTE_W] : ptr_q[BYTE_W-1:0];
  assign ptr     = ptr_q;

endmodule

// File: rtl/tpl_latch.sv
`timescale 1ns/1ps
module tpl_latch #(
  parameter  int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int NB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic              byte_hi,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_data,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [WORD_W-1:0] lat
);

  logic [WORD_W-1:0] lat_q;
  logic [WORD_W-1:0] nxt_byte;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic lane_sel;
    assign lane_sel = (g == 1) ? byte_hi : !byte_hi;
    assign nxt_byte[g*BYTE_W +: BYTE_W] =
      (byte_we && lane_sel) ? byte_data : lat_q[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_q <= '0;
    else if (load_en) lat_q <= load_data;
    else              lat_q <= nxt_byte;
  end

  assign rd_byte = rd_hi ? lat_q[WORD_W-1:BYTE_W] : lat_q[BYTE_W-1:0];
  assign lat     = lat_q;

endmodule

// File: rtl/tpl_unit.sv
`timescale 1ns/1ps
module tpl_unit
  import tpl_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_hi,
  input  logic              cmd_inc,
  input  logic [BYTE_W-1:0] cmd_data,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);

  tpl_dec_t          dec;
  logic              acc;
  logic              ph2_rd;
  logic              ph2_wr;
  logic              ph2_inc;
  logic [WORD_W-1:0] ptr_q;
  logic [WORD_W-1:0] lat_q;
  logic [BYTE_W-1:0] ptr_byte;
  logic [BYTE_W-1:0] lat_byte;
  logic              rd_valid_q;
  logic [BYTE_W-1:0] rd_data_q;

  assign acc = cmd_valid && cmd_ready;

  tpl_decode u_dec (
    .acc (acc),
    .op  (cmd_op),
    .dec (dec)
  );

  tpl_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_tbl (dec.tbl_rd || dec.tbl_wr),
    .start_wr  (dec.tbl_wr),
    .start_inc (cmd_inc),
    .ready     (cmd_ready),
    .ph2_rd    (ph2_rd),
    .ph2_wr    (ph2_wr),
    .ph2_inc   (ph2_inc)
  );

  tpl_ptr #(.BYTE_W(BYTE_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (dec.ptr_wr),
    .ld_hi   (cmd_hi),
    .ld_data (cmd_data),
    .inc_en  (ph2_inc),
    .rd_hi   (cmd_hi),
    .rd_byte (ptr_byte),
    .ptr     (ptr_q)
  );

  tpl_latch #(.BYTE_W(BYTE_W)) u_lat (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_we   (dec.lat_wr || dec.tbl_wr),
    .byte_hi   (cmd_hi),
    .byte_data (cmd_data),
    .load_en   (ph2_rd),
    .load_data (mem_rdata),
    .rd_hi     (cmd_hi),
    .rd_byte   (lat_byte),
    .lat       (lat_q)
  );

  // Byte returned to the core, one cycle after acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= dec.tbl_rd || dec.lat_rd || dec.ptr_rd;
      if (dec.tbl_rd || dec.lat_rd || dec.ptr_rd)
        rd_data_q <= dec.ptr_rd ? ptr_byte : lat_byte;
    end
  end

  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign mem_rd    = ph2_rd;
  assign mem_wr    = ph2_wr;
  assign mem_addr  = ptr_q;
  assign mem_wdata = lat_q;

endmodule

// File: rtl/tpl_unit_chk.sv
`timescale 1ns/1ps
module tpl_unit_chk #(
  parameter  int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic              rd_valid,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_rdata,
  input logic              ph2_inc,
  input logic [WORD_W-1:0] ptr_q,
  input logic [WORD_W-1:0] lat_q
);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_no_back_to_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));

  p_busy_in_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !cmd_ready);

  p_read_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd0) |=> mem_rd);

  p_write_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd1) |=> mem_wr);

  p_latch_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (lat_q == $past(mem_rdata)));

  p_post_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && ph2_inc) |=> (ptr_q == $past(mem_addr) + WORD_W'(1)));

  p_no_inc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !ph2_inc) |=> $stable(ptr_q));

  p_inc_only_in_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ph2_inc |-> (mem_rd || mem_wr));

  p_rvalid_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && cmd_ready));

endmodule

bind tpl_unit tpl_unit_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .rd_valid  (rd_valid),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata),
  .ph2_inc   (ph2_inc),
  .ptr_q     (ptr_q),
  .lat_q     (lat_q)
);

// File: tb/tpl_unit_tb.sv
`timescale 1ns/1ps
module tpl_unit_tb;

  localparam int BW = 8;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = 3'd0;
  logic          cmd_hi = 1'b0;
  logic          cmd_inc = 1'b0;
  logic [BW-1:0] cmd_data = '0;
  logic          rd_valid;
  logic [BW-1:0] rd_data;
  logic          mem_rd;
  logic          mem_wr;
  logic [WW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata;
  logic [WW-1:0] mem_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // Memory model: each word is its address XOR a fixed pattern
  assign mem_rdata = mem_addr ^ 16'h5A3C;

  tpl_unit #(.BYTE_W(BW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_hi    (cmd_hi),
    .cmd_inc   (cmd_inc),
    .cmd_data  (cmd_data),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issues one command; returns at the falling edge after acceptance
  task automatic send(input logic [2:0] op, input logic hi, input logic inc, input logic [7:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_hi = hi; cmd_inc = inc; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_byte(input string req, input logic [2:0] op, input logic hi, output logic [7:0] v);
    send(op, hi, 1'b0, 8'h00);
    chk(req, rd_valid, 1'b1);
    v = rd_data;
  endtask

  task automatic read_ptr(input string req, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_byte(req, 3'd5, 1'b0, lo);
    rd_byte(req, 3'd5, 1'b1, hi);
    v = {hi, lo};
  endtask

  task automatic read_lat(input string req, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_byte(req, 3'd2, 1'b0, lo);
    rd_byte(req, 3'd2, 1'b1, hi);
    v = {hi, lo};
  endtask

  task automatic set_ptr(input logic [15:0] v);
    send(3'd4, 1'b0, 1'b0, v[7:0]);
    send(3'd4, 1'b1, 1'b0, v[15:8]);
  endtask

  task automatic set_lat(input logic [15:0] v);
    send(3'd3, 1'b0, 1'b0, v[7:0]);
    send(3'd3, 1'b1, 1'b0, v[15:8]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] got;
    logic [15:0] ptrs [6];
    ptrs[0] = 16'h0000; ptrs[1] = 16'h00FF; ptrs[2] = 16'h7FFF;
    ptrs[3] = 16'hFFFE; ptrs[4] = 16'hFFFF; ptrs[5] = 16'h1234;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ready", cmd_ready, 1'b1);
    chk("R1 mem_rd", mem_rd, 1'b0);
    chk("R1 mem_wr", mem_wr, 1'b0);
    chk("R1 rd_valid", rd_valid, 1'b0);
    rst_n = 1'b1;
    read_ptr("R1 ptr", got);  chk("R1 ptr value", got, 16'h0000);
    read_lat("R1 lat", got);  chk("R1 lat value", got, 16'h0000);

    // R2 R3: latch byte sweep
    for (int v = 0; v < 256; v++) begin
      send(3'd3, 1'b1, 1'b0, ~v[7:0]);
      chk("R7 ready after single op", cmd_ready, 1'b1);
      send(3'd3, 1'b0, 1'b0, v[7:0]);
      read_lat("R3 latch read", got);
      chk("R2 latch bytes", got, {~v[7:0], v[7:0]});
    end

    // R4: pointer byte sweep
    for (int v = 0; v < 256; v++) begin
      set_ptr({v[7:0], ~v[7:0]});
      read_ptr("R3 ptr read", got);
      chk("R4 ptr bytes", got, {v[7:0], ~v[7:0]});
    end
    set_ptr(16'hAB00);
    send(3'd4, 1'b0, 1'b0, 8'hCD);
    read_ptr("R4 ptr read", got);
    chk("R4 low write keeps high", got, 16'hABCD);

    // R5 R6 R8 R10: table command sweep
    for (int pi = 0; pi < 6; pi++) begin
      for (int op = 0; op < 2; op++) begin
        for (int hi = 0; hi < 2; hi++) begin
          for (int inc = 0; inc < 2; inc++) begin
            logic [15:0] p, l, expl, expp;
            logic [7:0]  d;
            p = ptrs[pi];
            l = p ^ 16'h9617;
            d = p[7:0] ^ 8'h3E;
            set_ptr(p);
            set_lat(l);
            send(op[2:0], hi[0], inc[0], d);
            chk("R7 ready low in nop", cmd_ready, 1'b0);
            chk("R5 R6 mem_addr", mem_addr, p);
            if (op == 0) begin
              chk("R5 mem_rd", mem_rd, 1'b1);
              chk("R10 no wr on read", mem_wr, 1'b0);
              chk("R5 rd_valid", rd_valid, 1'b1);
              chk("R5 old latch byte", rd_data, hi ? l[15:8] : l[7:0]);
              expl = p ^ 16'h5A3C;
            end else begin
              expl = hi ? {d, l[7:0]} : {l[15:8], d};
              chk("R6 mem_wr", mem_wr, 1'b1);
              chk("R10 no rd on write", mem_rd, 1'b0);
              chk("R6 mem_wdata", mem_wdata, expl);
            end
            expp = inc ? p + 16'h0001 : p;
            @(negedge clk);
            chk("R10 strobes one cycle", {mem_rd, mem_wr}, 2'b00);
            chk("R7 ready back", cmd_ready, 1'b1);
            read_lat("R5 R6 latch", got);
            chk("R5 R6 latch after", got, expl);
            read_ptr("R8 ptr", got);
            chk("R8 ptr after", got, expp);
          end
        end
      end
    end

    // R8: increment ignored on non-table commands
    set_ptr(16'h2222);
    send(3'd3, 1'b0, 1'b1, 8'h11);
    send(3'd2, 1'b0, 1'b1, 8'h00);
    read_ptr("R8 ignore", got);
    chk("R8 inc ignored", got, 16'h2222);

    // R7: command held during nop cycle is taken afterwards
    set_ptr(16'h0040);
    set_lat(16'h0000);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_hi = 1'b0; cmd_inc = 1'b1; cmd_data = 8'h00;
    @(negedge clk);
    cmd_op = 3'd3; cmd_hi = 1'b1; cmd_inc = 1'b0; cmd_data = 8'h77;
    chk("R7 held ready low", cmd_ready, 1'b0);
    @(negedge clk);
    chk("R7 ready after nop", cmd_ready, 1'b1);
    @(negedge clk);
    cmd_valid = 1'b0;
    read_lat("R7 held", got);
    chk("R7 held write lands after load", got, {8'h77, 8'h7C});
    read_ptr("R7 held", got);
    chk("R7 ptr stepped once", got, 16'h0041);

    // R9: unused codes
    set_ptr(16'h5E5E);
    set_lat(16'hA1B2);
    for (int c = 6; c < 8; c++) begin
      send(c[2:0], 1'b1, 1'b1, 8'hFF);
      chk("R9 no rd_valid", rd_valid, 1'b0);
      chk("R9 no strobe", {mem_rd, mem_wr}, 2'b00);
      chk("R9 ready", cmd_ready, 1'b1);
    end
    read_ptr("R9 ptr", got);  chk("R9 ptr kept", got, 16'h5E5E);
    read_lat("R9 lat", got);  chk("R9 lat kept", got, 16'hA1B2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule